// File: doc/BRIEF.md
# Baseband Gain Controller with Open, Local and External Loops

This block scales a stream of complex baseband samples by a 16-bit unsigned gain, saturates each scaled sample to the signed 12-bit output range, and adapts the gain. The aim is to keep output amplitude as large as possible without clipping. The gain uses a 4.12 fixed-point format: 4096 is unity, 0 is the minimum and 65535 is the maximum. It always restarts from a programmed starting value that is loaded by a strobe.

A 2-bit mode input selects the gain policy. In the open policy the gain does not move. In the local policy, clipping at the output lowers the gain by a large step. A run of clean samples raises it again by a smaller step. In the external policy, a downstream device drives a single control pin. The block resynchronizes that pin and reads it as a raise or lower request, applying one step for each valid sample. The current gain can be read back as two status bytes, with the low byte first.

Top module: `bb_gain_ctrl`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_i`, `out_q` and `out_clip` update only for valid samples, and always with one cycle of latency.
- R2: Each output channel equals floor(sample × gain / 4096). The sample is signed and the gain is the unsigned value held before the sample's clock edge.
- R3: A result above 2047 becomes 2047, and a result below −2048 becomes −2048. `out_clip` is 1 when either channel of that sample saturated.
- R4: With `load_gain` high, the gain becomes `init_gain` on the next edge. This takes priority over any loop update in the same cycle, and it restarts the clean-sample count.
- R5: With mode 0 (open) or mode 3 (treated as open), the gain never changes except through a load, even when samples clip.
- R6: With mode 1 (local), each clipped valid sample lowers the gain by 256, stopping at 0.
- R7: With mode 1, every 8th consecutive unclipped valid sample raises the gain by 64, capped at 65535. A clipped sample restarts the count.
- R8: With mode 2 (external), `agc_ext` passes through a two-flop synchronizer. Each valid sample then raises the gain by 16 if the synchronized level is 1, or lowers it by 16 if the level is 0. The result saturates at 0 and 65535.
- R9: `gain_lo` is gain bits 7:0 and `gain_hi` is bits 15:8. After reset the gain is 4096, the output samples are 0, and `out_valid` and `out_clip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Signed in-phase sample |
| in_q | input | 12 | Signed quadrature sample |
| mode | input | 2 | Gain policy: 0 open, 1 local, 2 external, 3 open |
| init_gain | input | 16 | Gain value to load |
| load_gain | input | 1 | Load strobe for `init_gain` |
| agc_ext | input | 1 | Asynchronous raise(1)/lower(0) request |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Scaled, saturated in-phase sample |
| out_q | output | 12 | Scaled, saturated quadrature sample |
| out_clip | output | 1 | Either channel of the output sample saturated |
| gain_lo | output | 8 | Current gain, low byte |
| gain_hi | output | 8 | Current gain, high byte |

## Verification
Three results have fixed delays after a stimulus:
- The scaled samples, the clip flag and the loop's gain update all appear one edge after the valid sample. The bench drives each sample on a falling edge and reads all three results at the next falling edge.
- A gain load appears one edge after the strobe, so the bench reads the status bytes one falling edge after the load.
- A change on the external request pin takes two edges to reach the loop. The bench changes the pin and then waits three idle cycles with no valid samples before sending samples, so each step count is exact.

// File: rtl/bbg_pkg.sv
package bbg_pkg;
    typedef enum logic [1:0] {
        MODE_OPEN  = 2'd0,
        MODE_LOCAL = 2'd1,
        MODE_EXT   = 2'd2,
        MODE_RSVD  = 2'd3
    } agc_mode_e;
endpackage

// File: rtl/bbg_sync.sv
module bbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bbg_scale.sv
module bbg_scale #(
    parameter int IN_W   = 12,
    parameter int GAIN_W = 16,
    parameter int OUT_W  = 12,
    parameter int SHIFT  = 12
) (
    input  logic signed [IN_W-1:0]  sample,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [OUT_W-1:0] result,
    output logic                    sat
);
    localparam int PW = IN_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(sample) * $signed({1'b0, gain});
        shifted = prod >>> SHIFT;
        if (shifted > MAXV) begin
            result = MAXV[OUT_W-1:0];
            sat    = 1'b1;
        end else if (shifted < MINV) begin
            result = MINV[OUT_W-1:0];
            sat    = 1'b1;
        end else begin
            result = shifted[OUT_W-1:0];
            sat    = 1'b0;
        end
    end
endmodule

// File: rtl/bb_gain_ctrl.sv
module bb_gain_ctrl
    import bbg_pkg::*;
#(
    parameter int IN_W       = 12,
    parameter int OUT_W      = 12,
    parameter int GAIN_W     = 16,
    parameter int SHIFT      = 12,
    parameter int RESET_GAIN = 4096,
    parameter int STEP_DN    = 256,
    parameter int STEP_UP    = 64,
    parameter int STEP_EXT   = 16,
    parameter int WIN_LEN    = 8,
    parameter int SYNC_STG   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_i,
    input  logic signed [IN_W-1:0]   in_q,
    input  logic [1:0]               mode,
    input  logic [GAIN_W-1:0]        init_gain,
    input  logic                     load_gain,
    input  logic                     agc_ext,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q,
    output logic                     out_clip,
    output logic [7:0]               gain_lo,
    output logic [GAIN_W-9:0]        gain_hi
);
    localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int NCH   = 2;

    typedef struct packed {
        logic [GAIN_W-1:0]       gain;
        logic [CNT_W-1:0]        quiet;
        logic                    ov;
        logic signed [OUT_W-1:0] oi;
        logic signed [OUT_W-1:0] oq;
        logic                    clip;
    } state_t;

    state_t state_d, state_q;

    logic signed [IN_W-1:0]  ch_in  [NCH];
    logic signed [OUT_W-1:0] ch_res [NCH];
    logic [NCH-1:0]          ch_sat;
    logic                    ext_s;

    assign ch_in[0] = in_i;
    assign ch_in[1] = in_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bbg_scale #(
            .IN_W(IN_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
        ) u_scale (
            .sample(ch_in[c]),
            .gain  (state_q.gain),
            .result(ch_res[c]),
            .sat   (ch_sat[c])
        );
    end

    bbg_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(agc_ext), .q(ext_s)
    );

    function automatic logic [GAIN_W-1:0] gain_up(input logic [GAIN_W-1:0] g, input int step);
        logic [GAIN_W:0] s;
        s = {1'b0, g} + (GAIN_W + 1)'(step);
        return s[GAIN_W] ? {GAIN_W{1'b1}} : s[GAIN_W-1:0];
    endfunction

    function automatic logic [GAIN_W-1:0] gain_dn(input logic [GAIN_W-1:0] g, input int step);
        return (g < GAIN_W'(step)) ? '0 : g - GAIN_W'(step);
    endfunction

    always_comb begin
        logic any_clip;
        state_d  = state_q;
        any_clip = |ch_sat;
        state_d.ov = in_valid;
        if (in_valid) begin
            state_d.oi   = ch_res[0];
            state_d.oq   = ch_res[1];
            state_d.clip = any_clip;
        end
        case (agc_mode_e'(mode))
            MODE_LOCAL: begin
                if (in_valid) begin
                    if (any_clip) begin
                        state_d.gain  = gain_dn(state_q.gain, STEP_DN);
                        state_d.quiet = '0;
                    end else if (state_q.quiet == CNT_W'(WIN_LEN - 1)) begin
                        state_d.gain  = gain_up(state_q.gain, STEP_UP);
                        state_d.quiet = '0;
                    end else begin
                        state_d.quiet = state_q.quiet + 1'b1;
                    end
                end
            end
            MODE_EXT: begin
                state_d.quiet = '0;
                if (in_valid) begin
                    state_d.gain = ext_s ? gain_up(state_q.gain, STEP_EXT)
                                         : gain_dn(state_q.gain, STEP_EXT);
                end
            end
            default: state_d.quiet = '0;
        endcase
        if (load_gain) begin
            state_d.gain  = init_gain;
            state_d.quiet = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.gain <= GAIN_W'(RESET_GAIN);
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.ov;
    assign out_i     = state_q.oi;
    assign out_q     = state_q.oq;
    assign out_clip  = state_q.clip;
    assign gain_lo   = state_q.gain[7:0];
    assign gain_hi   = state_q.gain[GAIN_W-1:8];
endmodule

// File: rtl/bbg_checker.sv
module bbg_checker #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 12,
    parameter int GAIN_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [IN_W-1:0]  in_i,
    input logic signed [IN_W-1:0]  in_q,
    input logic [1:0]              mode,
    input logic [GAIN_W-1:0]       init_gain,
    input logic                    load_gain,
    input logic                    agc_ext,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q,
    input logic                    out_clip,
    input logic [7:0]              gain_lo,
    input logic [GAIN_W-9:0]       gain_hi
);
    logic [GAIN_W-1:0] g_now;
    assign g_now = {gain_hi, gain_lo};

    assert_valid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(out_clip)));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_gain |=> (g_now == $past(init_gain)));
    assert_open_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_gain && (mode == 2'd0 || mode == 2'd3)) |=> $stable(g_now));
    assert_clip_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_clip && $past(in_valid) && !$past(load_gain) && $past(mode) == 2'd1)
        |-> (g_now < $past(g_now) || $past(g_now) == '0));
    assert_ext_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !load_gain && mode == 2'd2)
        |=> (!$stable(g_now) || g_now == '0 || g_now == '1));
endmodule

bind bb_gain_ctrl bbg_checker #(
    .IN_W(IN_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .mode(mode), .init_gain(init_gain), .load_gain(load_gain), .agc_ext(agc_ext),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_clip(out_clip),
    .gain_lo(gain_lo), .gain_hi(gain_hi)
);

// File: tb/bb_gain_ctrl_tb.sv
module bb_gain_ctrl_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic [1:0]         mode = 2'd0;
    logic [15:0]        init_gain = '0;
    logic               load_gain = 1'b0;
    logic               agc_ext = 1'b0;
    logic               out_valid;
    logic signed [11:0] out_i;
    logic signed [11:0] out_q;
    logic               out_clip;
    logic [7:0]         gain_lo;
    logic [7:0]         gain_hi;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bb_gain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .mode(mode), .init_gain(init_gain), .load_gain(load_gain), .agc_ext(agc_ext),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_clip(out_clip),
        .gain_lo(gain_lo), .gain_hi(gain_hi)
    );

    typedef struct packed {
        logic signed [11:0] si;
        logic signed [11:0] sq;
        logic [15:0]        g;
        logic signed [11:0] ei;
        logic signed [11:0] eq;
        logic               ec;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{ 12'sd100,   -12'sd100,  16'd4096,  12'sd100,   -12'sd100,  1'b0},
        '{ 12'sd1000,  -12'sd1000, 16'd8192,  12'sd2000,  -12'sd2000, 1'b0},
        '{ 12'sd1500,   12'sd10,   16'd8192,  12'sd2047,   12'sd20,   1'b1},
        '{-12'sd1500,   12'sd0,    16'd8192, -12'sd2048,   12'sd0,    1'b1},
        '{ 12'sd2047,  -12'sd2048, 16'd2048,  12'sd1023,  -12'sd1024, 1'b0},
        '{-12'sd1,      12'sd1,    16'd1,    -12'sd1,      12'sd0,    1'b0},
        '{ 12'sd2047,   12'sd2047, 16'd65535, 12'sd2047,   12'sd2047, 1'b1},
        '{ 12'sd5,     -12'sd7,    16'd0,     12'sd0,      12'sd0,    1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gain_now();
        return int'({gain_hi, gain_lo});
    endfunction

    task automatic do_load(input int g, input int m);
        @(negedge clk);
        mode = 2'(m); init_gain = 16'(g); load_gain = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        load_gain = 1'b0;
    endtask

    task automatic send(input int si, input int sq);
        in_i = 12'(si); in_q = 12'(sq); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9", "reset gain_hi", int'(gain_hi), 16);
        check("R9", "reset gain_lo", int'(gain_lo), 0);
        check("R9", "reset out_valid", int'(out_valid), 0);
        check("R9", "reset out_clip", int'(out_clip), 0);
        check("R9", "reset out_i", int'(out_i), 0);

        // R2/R3/R5 vector table, open loop
        for (int v = 0; v < 8; v++) begin
            do_load(int'(VEC[v].g), 0);
            check("R4", "loaded gain", gain_now(), int'(VEC[v].g));
            send(int'(VEC[v].si), int'(VEC[v].sq));
            check("R2", "out_i", int'(out_i), int'(VEC[v].ei));
            check("R2", "out_q", int'(out_q), int'(VEC[v].eq));
            check("R3", "out_clip", int'(out_clip), int'(VEC[v].ec));
            check("R5", "open gain fixed", gain_now(), int'(VEC[v].g));
            check("R1", "out_valid high", int'(out_valid), 1);
            @(negedge clk);
            check("R1", "out_valid low", int'(out_valid), 0);
        end

        // R9 byte order
        do_load(16'h1234, 0);
        check("R9", "gain_lo byte", int'(gain_lo), 8'h34);
        check("R9", "gain_hi byte", int'(gain_hi), 8'h12);

        // R5 reserved mode acts open
        do_load(8192, 3);
        send(1500, 0);
        check("R5", "mode3 clip", int'(out_clip), 1);
        check("R5", "mode3 gain fixed", gain_now(), 8192);

        // R7 recovery after 8 clean samples
        do_load(4096, 1);
        for (int k = 0; k < 7; k++) send(10, 10);
        check("R7", "gain before window", gain_now(), 4096);
        send(10, 10);
        check("R7", "gain after window", gain_now(), 4160);

        // R6 clip lowers, R7 clip restarts window
        do_load(8192, 1);
        for (int k = 0; k < 5; k++) send(10, 10);
        send(1500, 0);
        check("R6", "clip lowers gain", gain_now(), 7936);
        for (int k = 0; k < 7; k++) send(10, 10);
        check("R7", "window restarted", gain_now(), 7936);
        send(10, 10);
        check("R7", "raise after restart", gain_now(), 8000);

        // R7 ceiling
        do_load(65520, 1);
        for (int k = 0; k < 8; k++) send(0, 0);
        check("R7", "raise capped", gain_now(), 65535);

        // R4 load beats loop update
        do_load(8192, 1);
        in_i = 12'sd1500; in_q = 12'sd0; in_valid = 1'b1;
        init_gain = 16'd3000; load_gain = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; load_gain = 1'b0;
        check("R4", "load priority gain", gain_now(), 3000);
        check("R4", "sample used old gain", int'(out_i), 2047);

        // R8 external loop
        agc_ext = 1'b1;
        do_load(1000, 2);
        idle(3);
        for (int k = 0; k < 3; k++) send(10, 10);
        check("R8", "ext raise", gain_now(), 1048);
        agc_ext = 1'b0;
        idle(3);
        for (int k = 0; k < 2; k++) send(10, 10);
        check("R8", "ext lower", gain_now(), 1016);
        do_load(5, 2);
        send(10, 10);
        check("R8", "ext floor", gain_now(), 0);
        agc_ext = 1'b1;
        idle(3);
        do_load(65528, 2);
        send(10, 10);
        check("R8", "ext ceiling", gain_now(), 65535);
        idle(2);
        check("R8", "no step without valid", gain_now(), 65535);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule